// File: doc/BRIEF.md
# Host-Coprocessor Mailbox

This block is a small two-sided register interface that links an 8-bit host bus to an embedded 32-bit coprocessor. Each direction has a one-byte data register and a flag that marks the byte as waiting to be read. The coprocessor can also raise an acknowledge flag for the host. Both sides can read one shared status byte that packs these flags together with the run state of the coprocessor.

The host also uses the block to hold the coprocessor in reset or to let it run. The reset output starts asserted after a system reset. A control write of zero releases the coprocessor, and that write also produces a single-cycle power-on pulse. Reads with side effects act only when their strobe is present in the cycle. When one side sets a flag in the same cycle that the other side clears it, the set is kept.

Top module: `mbox_bridge`

## Requirements
- R1: After reset, cop_reset is 1, cop_power_on is 0, both data bytes are 0, and the status byte reads 0x00.
- R2: The host window is active when host_bank bit 6 is 0 (banks 0x00–0x3F and 0x80–0xBF) and host_addr[15:12] is 0x3. Inside the window the register is chosen by host_addr AND 0xFF06: 0x3800 is data, 0x3802 is acknowledge/send, and 0x3804 is control/status. Any other host read returns host_open_bus, and a host write outside the window changes nothing.
- R3: A coprocessor write at I/O offset 0x00 loads the coprocessor-to-host byte and sets status bit 0. A host read of 0x3800 returns that byte and clears bit 0.
- R4: A host write of 0x3802 loads the host-to-coprocessor byte and sets status bit 3. A coprocessor read at offset 0x10 returns that byte and clears bit 3.
- R5: A coprocessor write at offset 0x10 sets status bit 2. A host read of 0x3802 clears bit 2 and returns host_open_bus.
- R6: The status byte has these bits: bit 0 is host-data-pending, bit 2 is acknowledge, bit 3 is coprocessor-data-pending, and bit 7 is 1 when the coprocessor is not held in reset. All other bits are 0. The host reads it at 0x3804 and the coprocessor reads the same value at offset 0x20.
- R7: A host write of 0x3804 with a nonzero value asserts cop_reset. A write of zero deasserts cop_reset.
- R8: A host write of zero to 0x3804 while cop_reset is asserted makes cop_power_on high for exactly the cycle after the write. A zero write while the coprocessor is already running makes no pulse.
- R9: When one side sets a flag and the other side clears it in the same cycle, the flag ends up set.
- R10: The coprocessor I/O region is selected by cop_addr[31:28] = 0x4, with the offset taken from cop_addr[5:0]. Coprocessor reads at other offsets or outside the region return 0. Coprocessor writes outside the region, and register addresses presented without a strobe, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_bank | input | 8 | Host bank number |
| host_addr | input | 16 | Host offset within the bank |
| host_rd | input | 1 | Host read strobe, single cycle |
| host_wr | input | 1 | Host write strobe, single cycle |
| host_wdata | input | 8 | Host write data |
| host_open_bus | input | 8 | Value returned for unmapped host reads |
| host_rdata | output | 8 | Host read data (combinational) |
| cop_addr | input | 32 | Coprocessor byte address |
| cop_rd | input | 1 | Coprocessor read strobe |
| cop_wr | input | 1 | Coprocessor write strobe |
| cop_wdata | input | 8 | Coprocessor write data |
| cop_rdata | output | 8 | Coprocessor read data (combinational) |
| cop_reset | output | 1 | Holds the coprocessor in reset when 1 |
| cop_power_on | output | 1 | One-cycle restart pulse on release |

## Verification
The hardest case to reach from the ports is a collision, where one side sets a flag in the same clock edge that the other side's read clears it. A plain sequence of host and coprocessor accesses never produces this. The bench therefore drives both buses in the same cycle for each of the three flags, and then reads the status byte to confirm that the flag is set. It also holds a data address without a strobe for one cycle. This shows that the decoded address alone does not clear anything.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    localparam int DATA_W = 8;

    // host register selectors after masking
    localparam logic [15:0] HOST_SEL_MASK = 16'hFF06;
    localparam logic [15:0] HOST_REG_DATA = 16'h3800;
    localparam logic [15:0] HOST_REG_XFER = 16'h3802;
    localparam logic [15:0] HOST_REG_CTRL = 16'h3804;

    // coprocessor I/O region and offsets
    localparam logic [3:0] COP_IO_REGION = 4'h4;
    localparam logic [5:0] COP_OFF_TX    = 6'h00;
    localparam logic [5:0] COP_OFF_RX    = 6'h10;
    localparam logic [5:0] COP_OFF_STAT  = 6'h20;

    typedef enum logic [1:0] {
        HSEL_NONE,
        HSEL_DATA,
        HSEL_XFER,
        HSEL_CTRL
    } host_sel_e;

    typedef enum logic [1:0] {
        CSEL_NONE,
        CSEL_TX,
        CSEL_RX,
        CSEL_STAT
    } cop_sel_e;

    typedef struct packed {
        logic rd_data;
        logic rd_xfer;
        logic wr_xfer;
        logic wr_ctrl;
    } host_op_t;

    typedef struct packed {
        logic rd_rx;
        logic wr_tx;
        logic wr_ack;
    } cop_op_t;

    typedef struct packed {
        logic [DATA_W-1:0] c2h_byte;
        logic [DATA_W-1:0] h2c_byte;
        logic              host_pend;
        logic              cop_pend;
        logic              ack;
        logic              hold;
        logic              pwr_pulse;
    } mbox_state_t;

    function automatic logic [7:0] pack_status(mbox_state_t s);
        pack_status = {~s.hold, 3'b000, s.cop_pend, s.ack, 1'b0, s.host_pend};
    endfunction

endpackage

// File: rtl/mbox_host_dec.sv
module mbox_host_dec
    import mbox_pkg::*;
#(
    parameter int BANK_W = 8,
    parameter int ADDR_W = 16
) (
    input  logic [BANK_W-1:0] bank,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output host_sel_e         sel,
    output host_op_t          op
);
    localparam int BANK_GAP_BIT = BANK_W - 2;

    logic              in_window;
    logic [ADDR_W-1:0] masked;
    logic              unused_bits;

    assign in_window   = !bank[BANK_GAP_BIT] && (addr[ADDR_W-1 -: 4] == 4'h3);
    assign masked      = addr & HOST_SEL_MASK;
    assign unused_bits = ^{bank[BANK_W-1], bank[BANK_GAP_BIT-1:0]};

    always_comb begin
        sel = HSEL_NONE;
        if (in_window) begin
            unique case (masked)
                HOST_REG_DATA: sel = HSEL_DATA;
                HOST_REG_XFER: sel = HSEL_XFER;
                HOST_REG_CTRL: sel = HSEL_CTRL;
                default:       sel = HSEL_NONE;
            endcase
        end
    end

    always_comb begin
        op         = '0;
        op.rd_data = rd && (sel == HSEL_DATA);
        op.rd_xfer = rd && (sel == HSEL_XFER);
        op.wr_xfer = wr && (sel == HSEL_XFER);
        op.wr_ctrl = wr && (sel == HSEL_CTRL);
    end

endmodule

// File: rtl/mbox_cop_dec.sv
module mbox_cop_dec
    import mbox_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 6
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output cop_sel_e          sel,
    output cop_op_t           op
);
    localparam int REGION_W = 4;

    logic             in_region;
    logic [OFF_W-1:0] offset;
    logic             unused_mid;

    assign in_region  = (addr[ADDR_W-1 -: REGION_W] == COP_IO_REGION);
    assign offset     = addr[OFF_W-1:0];
    assign unused_mid = ^addr[ADDR_W-REGION_W-1:OFF_W];

    always_comb begin
        sel = CSEL_NONE;
        if (in_region) begin
            unique case (offset)
                COP_OFF_TX:   sel = CSEL_TX;
                COP_OFF_RX:   sel = CSEL_RX;
                COP_OFF_STAT: sel = CSEL_STAT;
                default:      sel = CSEL_NONE;
            endcase
        end
    end

    always_comb begin
        op        = '0;
        op.rd_rx  = rd && (sel == CSEL_RX);
        op.wr_tx  = wr && (sel == CSEL_TX);
        op.wr_ack = wr && (sel == CSEL_RX);
    end

endmodule

// File: rtl/mbox_regs.sv
module mbox_regs
    import mbox_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  host_op_t          host_op,
    input  cop_op_t           cop_op,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [DATA_W-1:0] cop_wdata,
    output mbox_state_t       state_q
);
    mbox_state_t state_d;

    always_comb begin
        state_d           = state_q;
        state_d.pwr_pulse = 1'b0;

        if (cop_op.wr_tx)    state_d.c2h_byte = cop_wdata;
        if (host_op.wr_xfer) state_d.h2c_byte = host_wdata;

        // clears are applied first so a same-cycle set overrides them
        if (host_op.rd_data) state_d.host_pend = 1'b0;
        if (cop_op.rd_rx)    state_d.cop_pend  = 1'b0;
        if (host_op.rd_xfer) state_d.ack       = 1'b0;

        if (cop_op.wr_tx)    state_d.host_pend = 1'b1;
        if (host_op.wr_xfer) state_d.cop_pend  = 1'b1;
        if (cop_op.wr_ack)   state_d.ack       = 1'b1;

        if (host_op.wr_ctrl) begin
            state_d.hold      = |host_wdata;
            state_d.pwr_pulse = state_q.hold && !(|host_wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= '0;
            state_q.hold <= 1'b1;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/mbox_bridge.sv
module mbox_bridge
    import mbox_pkg::*;
#(
    parameter int HOST_BANK_W = 8,
    parameter int HOST_ADDR_W = 16,
    parameter int COP_ADDR_W  = 32,
    parameter int COP_OFF_W   = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [HOST_BANK_W-1:0] host_bank,
    input  logic [HOST_ADDR_W-1:0] host_addr,
    input  logic                   host_rd,
    input  logic                   host_wr,
    input  logic [7:0]             host_wdata,
    input  logic [7:0]             host_open_bus,
    output logic [7:0]             host_rdata,
    input  logic [COP_ADDR_W-1:0]  cop_addr,
    input  logic                   cop_rd,
    input  logic                   cop_wr,
    input  logic [7:0]             cop_wdata,
    output logic [7:0]             cop_rdata,
    output logic                   cop_reset,
    output logic                   cop_power_on
);
    host_sel_e   h_sel;
    host_op_t    h_op;
    cop_sel_e    c_sel;
    cop_op_t     c_op;
    mbox_state_t st_q;
    logic [7:0]  stat;

    mbox_host_dec #(
        .BANK_W (HOST_BANK_W),
        .ADDR_W (HOST_ADDR_W)
    ) u_host_dec (
        .bank (host_bank),
        .addr (host_addr),
        .rd   (host_rd),
        .wr   (host_wr),
        .sel  (h_sel),
        .op   (h_op)
    );

    mbox_cop_dec #(
        .ADDR_W (COP_ADDR_W),
        .OFF_W  (COP_OFF_W)
    ) u_cop_dec (
        .addr (cop_addr),
        .rd   (cop_rd),
        .wr   (cop_wr),
        .sel  (c_sel),
        .op   (c_op)
    );

    mbox_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_op    (h_op),
        .cop_op     (c_op),
        .host_wdata (host_wdata),
        .cop_wdata  (cop_wdata),
        .state_q    (st_q)
    );

    assign stat = pack_status(st_q);

    always_comb begin
        unique case (h_sel)
            HSEL_DATA: host_rdata = st_q.c2h_byte;
            HSEL_CTRL: host_rdata = stat;
            default:   host_rdata = host_open_bus;
        endcase
    end

    always_comb begin
        unique case (c_sel)
            CSEL_RX:   cop_rdata = st_q.h2c_byte;
            CSEL_STAT: cop_rdata = stat;
            default:   cop_rdata = 8'h00;
        endcase
    end

    assign cop_reset    = st_q.hold;
    assign cop_power_on = st_q.pwr_pulse;

endmodule

// File: rtl/mbox_bridge_chk.sv
module mbox_bridge_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [7:0]  host_bank,
    input logic [15:0] host_addr,
    input logic        host_wr,
    input logic [7:0]  host_wdata,
    input logic [31:0] cop_addr,
    input logic        cop_wr,
    input logic        cop_reset,
    input logic        cop_power_on,
    input logic [7:0]  stat
);
    logic h_win, h_xfer_wr, h_ctrl_wr, c_tx_wr;

    assign h_win     = !host_bank[6] && (host_addr[15:12] == 4'h3);
    assign h_xfer_wr = host_wr && h_win && ((host_addr & 16'hFF06) == 16'h3802);
    assign h_ctrl_wr = host_wr && h_win && ((host_addr & 16'hFF06) == 16'h3804);
    assign c_tx_wr   = cop_wr && (cop_addr[31:28] == 4'h4) && (cop_addr[5:0] == 6'h00);

    // R8
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cop_power_on |=> !cop_power_on);

    // R8
    pulse_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h_ctrl_wr && cop_reset && host_wdata == 8'h00) |=> (cop_power_on && !cop_reset));

    // R7
    hold_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h_ctrl_wr && host_wdata != 8'h00) |=> (cop_reset && !cop_power_on));

    // R3
    host_pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_tx_wr |=> stat[0]);

    // R4
    cop_pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        h_xfer_wr |=> stat[3]);

    // R6
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat & 8'h72) == 8'h00);

    // R6
    run_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat[7] != cop_reset);

endmodule

bind mbox_bridge mbox_bridge_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_bank    (host_bank),
    .host_addr    (host_addr),
    .host_wr      (host_wr),
    .host_wdata   (host_wdata),
    .cop_addr     (cop_addr),
    .cop_wr       (cop_wr),
    .cop_reset    (cop_reset),
    .cop_power_on (cop_power_on),
    .stat         (stat)
);

// File: tb/mbox_bridge_tb.sv
`timescale 1ns/1ps
module mbox_bridge_tb;

    localparam logic [7:0] OPEN = 8'hEE;
    // vector: op(2) req(4) addr(16) data(8) expect(8); op 0=host wr,1=host rd,2=cop wr,3=cop rd
    localparam int NV = 21;
    localparam logic [37:0] VEC [NV] = '{
        {2'd1, 4'd1,  16'h3804, 8'h00, 8'h00}, // R1 status after reset
        {2'd0, 4'd7,  16'h3804, 8'h00, 8'h00}, // R7 release
        {2'd1, 4'd6,  16'h3804, 8'h00, 8'h80}, // R6 run bit
        {2'd2, 4'd3,  16'h0000, 8'h5A, 8'h00}, // R3 cop sends
        {2'd1, 4'd3,  16'h3804, 8'h00, 8'h81},
        {2'd3, 4'd6,  16'h0020, 8'h00, 8'h81}, // R6 same status on cop side
        {2'd1, 4'd3,  16'h3800, 8'h00, 8'h5A},
        {2'd1, 4'd3,  16'h3804, 8'h00, 8'h80},
        {2'd0, 4'd4,  16'h3802, 8'hC3, 8'h00}, // R4 host sends
        {2'd1, 4'd4,  16'h3804, 8'h00, 8'h88},
        {2'd3, 4'd4,  16'h0010, 8'h00, 8'hC3},
        {2'd3, 4'd4,  16'h0020, 8'h00, 8'h80},
        {2'd2, 4'd5,  16'h0010, 8'h11, 8'h00}, // R5 ack
        {2'd1, 4'd5,  16'h3804, 8'h00, 8'h84},
        {2'd1, 4'd5,  16'h3802, 8'h00, OPEN},
        {2'd1, 4'd5,  16'h3804, 8'h00, 8'h80},
        {2'd1, 4'd2,  16'h3809, 8'h00, 8'h5A}, // R2 mirror of data
        {2'd1, 4'd2,  16'h3806, 8'h00, OPEN},  // R2 unmapped
        {2'd3, 4'd10, 16'h0008, 8'h00, 8'h00}, // R10 other offset
        {2'd0, 4'd7,  16'h3804, 8'h01, 8'h00}, // R7 hold again
        {2'd1, 4'd7,  16'h3804, 8'h00, 8'h00}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  host_bank = 8'h00;
    logic [15:0] host_addr = 16'h0000;
    logic        host_rd = 1'b0, host_wr = 1'b0;
    logic [7:0]  host_wdata = 8'h00;
    logic [7:0]  host_rdata;
    logic [31:0] cop_addr = 32'h0;
    logic        cop_rd = 1'b0, cop_wr = 1'b0;
    logic [7:0]  cop_wdata = 8'h00;
    logic [7:0]  cop_rdata;
    logic        cop_reset, cop_power_on;
    int          checks = 0, errors = 0;

    always #2 clk = ~clk;

    mbox_bridge u_dut (
        .clk(clk), .rst_n(rst_n),
        .host_bank(host_bank), .host_addr(host_addr), .host_rd(host_rd), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_open_bus(OPEN), .host_rdata(host_rdata),
        .cop_addr(cop_addr), .cop_rd(cop_rd), .cop_wr(cop_wr), .cop_wdata(cop_wdata),
        .cop_rdata(cop_rdata), .cop_reset(cop_reset), .cop_power_on(cop_power_on)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic idle();
        host_rd = 0; host_wr = 0; cop_rd = 0; cop_wr = 0;
    endtask

    task automatic host_access(input logic [7:0] bank, input logic [15:0] a, input bit wr,
                               input logic [7:0] wd, output logic [7:0] rd);
        @(negedge clk);
        host_bank = bank; host_addr = a; host_wdata = wd;
        host_wr = wr; host_rd = !wr;
        #1 rd = host_rdata;
        @(posedge clk); #1 idle();
    endtask

    task automatic cop_access(input logic [31:0] a, input bit wr,
                              input logic [7:0] wd, output logic [7:0] rd);
        @(negedge clk);
        cop_addr = a; cop_wdata = wd; cop_wr = wr; cop_rd = !wr;
        #1 rd = cop_rdata;
        @(posedge clk); #1 idle();
    endtask

    function automatic logic [31:0] io(input logic [5:0] off);
        return {4'h4, 22'h0, off};
    endfunction

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        // R1 reset outputs
        check("R1 cop_reset", {7'd0, cop_reset}, 8'h01);
        check("R1 power_on", {7'd0, cop_power_on}, 8'h00);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [1:0] op;
            logic [3:0] rq;
            logic [15:0] a;
            logic [7:0] d, e;
            string tag;
            {op, rq, a, d, e} = VEC[i];
            tag = $sformatf("R%0d vec%0d", rq, i);
            case (op)
                2'd0: host_access(8'h00, a, 1'b1, d, v);
                2'd1: begin host_access(8'h00, a, 1'b0, d, v); check(tag, v, e); end
                2'd2: cop_access(io(a[5:0]), 1'b1, d, v);
                default: begin cop_access(io(a[5:0]), 1'b0, d, v); check(tag, v, e); end
            endcase
        end

        // R8 release pulse: write zero while held
        @(negedge clk);
        host_addr = 16'h3804; host_wdata = 8'h00; host_wr = 1'b1;
        @(posedge clk); #1 idle();
        check("R8 pulse high", {6'd0, cop_power_on, cop_reset}, 8'h02);
        @(posedge clk); #1;
        check("R8 pulse ends", {7'd0, cop_power_on}, 8'h00);
        // R8 zero write while running: no pulse
        @(negedge clk);
        host_wr = 1'b1;
        @(posedge clk); #1 idle();
        check("R8 no pulse when running", {7'd0, cop_power_on}, 8'h00);

        // R2 banks
        host_access(8'h85, 16'h3804, 1'b0, 8'h00, v);
        check("R2 bank 0x85", v, 8'h80);
        host_access(8'h40, 16'h3804, 1'b0, 8'h00, v);
        check("R2 bank 0x40", v, OPEN);
        host_access(8'hC0, 16'h3804, 1'b0, 8'h00, v);
        check("R2 bank 0xC0", v, OPEN);
        host_access(8'h00, 16'h2804, 1'b0, 8'h00, v);
        check("R2 offset 0x2804", v, OPEN);
        host_access(8'h40, 16'h3802, 1'b1, 8'h77, v);
        host_access(8'h00, 16'h3804, 1'b0, 8'h00, v);
        check("R2 write outside window ignored", v, 8'h80);

        // R10 writes outside the I/O region ignored
        cop_access(32'hE000_0000, 1'b1, 8'h99, v);
        host_access(8'h00, 16'h3804, 1'b0, 8'h00, v);
        check("R10 write outside region", v, 8'h80);
        cop_access(32'hA000_0010, 1'b0, 8'h00, v);
        check("R10 read outside region", v, 8'h00);

        // R9 collisions: set and clear in the same cycle
        @(negedge clk);
        cop_addr = io(6'h00); cop_wdata = 8'h3C; cop_wr = 1'b1;
        host_addr = 16'h3800; host_rd = 1'b1;
        @(posedge clk); #1 idle();
        @(negedge clk);
        cop_addr = io(6'h10); cop_rd = 1'b1;
        host_addr = 16'h3802; host_wdata = 8'h42; host_wr = 1'b1;
        @(posedge clk); #1 idle();
        @(negedge clk);
        cop_addr = io(6'h10); cop_wr = 1'b1;
        host_addr = 16'h3802; host_rd = 1'b1;
        @(posedge clk); #1 idle();
        host_access(8'h00, 16'h3804, 1'b0, 8'h00, v);
        check("R9 set wins on all flags", v, 8'h8D);

        // R10 address held without strobe: no clear
        @(negedge clk);
        host_addr = 16'h3800; cop_addr = io(6'h10);
        @(posedge clk); #1;
        host_access(8'h00, 16'h3804, 1'b0, 8'h00, v);
        check("R10 no strobe no side effect", v, 8'h8D);
        host_access(8'h00, 16'h3800, 1'b0, 8'h00, v);
        check("R3 byte after collision", v, 8'h3C);
        cop_access(io(6'h10), 1'b0, 8'h00, v);
        check("R4 byte after collision", v, 8'h42);
        cop_access(io(6'h20), 1'b0, 8'h00, v);
        check("R6 status after reads", v, 8'h84);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule